// File: doc/BRIEF.md
# Parity-Protected Nibble Register Responder

This block is the device side of a narrow parallel read link that exposes a time-of-day snapshot. A host drives a 5-bit register number. The block answers on five parallel outputs with a 4-bit data nibble and an odd-parity bit. Each 8-bit time or date field is split across two consecutive register numbers. Register numbers 0 and 15 return fixed patterns, so the host can confirm that the link is wired correctly before it trusts any data.

The time fields, the status flags and the weekday come from a separate clock source as parallel inputs. When the register number changes, the block copies all of these inputs into a snapshot. The two nibbles of one field therefore come from the same instant. After a programmable number of clock cycles, the answer for the new number appears on the outputs. Until then, the previous answer is held.

The delay is a parameter. At the intended clock rate it can be set to any value inside the 2 ms answer window the host allows.

Top module: `nibble_reg_responder`

## Requirements
- R1: Register number 0 answers `00000`.
- R2: Register number 15 answers `01111`: the parity position (bit 4) is low and data bits 3..0 are high.
- R3: Register numbers 16 to 31 answer `00000`.
- R4: For register numbers 1 to 14, bits 3..0 carry the data nibble and bit 4 is set so that the five answer bits hold an odd number of ones.
- R5: The field pairs are 2/3 seconds, 4/5 minutes, 6/7 hours, 8/9 day, 10/11 month and 12/13 year. The even number of each pair returns bits 3..0 of its field and the odd number returns bits 7..4.
- R6: Register number 1 returns the 4-bit status input unchanged. Bit 1 means radio-synchronised, bit 2 means UTC+2 summer time and bit 3 means UTC+1 winter time.
- R7: Register number 14 returns the weekday (1 = Monday through 7 = Sunday) in bits 2..0, with bit 3 low.
- R8: Let E be the clock edge at which a changed register number is first sampled. The answer changes at edge E + RESP_DELAY and keeps its previous value on every earlier edge.
- R9: The time, status and weekday inputs are captured at edge E. Later changes to those inputs do not alter the answer while the register number stays the same.
- R10: If the register number changes again before the answer is due, the delay restarts from the newer change and only the newest number is answered.
- R11: While reset is asserted, and after it is released with the register number at 0, the answer is `00000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 5 | Register number driven by the host |
| status_in | input | 4 | Status flags from the clock source |
| sec_in | input | 8 | Seconds field |
| min_in | input | 8 | Minutes field |
| hour_in | input | 8 | Hours field |
| day_in | input | 8 | Day-of-month field |
| month_in | input | 8 | Month field |
| year_in | input | 8 | Year field |
| wday_in | input | 3 | Weekday, 1 = Monday to 7 = Sunday |
| answer | output | 5 | Parity bit (bit 4) and data nibble (bits 3..0) |

## Verification
If the latched register number or the snapshot is corrupted, the fault shows as a wrong nibble or as even parity on the answer exactly RESP_DELAY edges after the address change, and at no other time. If the delay counter is off by one, the new answer appears one edge early or one edge late. The bench therefore samples the old value on the edge just before the due edge and the new value on the due edge itself. If the snapshot is refreshed when the register number has not changed, the answer drifts a full delay after the inputs move, even though no address change happened. The bench checks for this by changing the inputs while the number is held steady.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
  localparam int ADDR_W     = 5;
  localparam int NIB_W      = 4;
  localparam int ANS_W      = NIB_W + 1;
  localparam int FIELD_W    = 2 * NIB_W;
  localparam int NUM_FIELDS = 6;   // sec, min, hour, day, month, year
  localparam int WDAY_W     = 3;

  localparam logic [ADDR_W-1:0] REG_STATUS     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_FIELD_BASE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] REG_WEEKDAY    = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] REG_LOOPBACK   = ADDR_W'(15);
  localparam logic [ANS_W-1:0]  LOOPBACK_ANS   = {1'b0, {NIB_W{1'b1}}};

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    logic [NIB_W-1:0]             status;
    field_t [NUM_FIELDS-1:0]      fld;
    logic [WDAY_W-1:0]            wday;
  } snap_t;

  function automatic logic odd_fill(input logic [NIB_W-1:0] nib);
    return ~(^nib);
  endfunction
endpackage

// File: rtl/nrr_snapshot.sv
module nrr_snapshot
  import nrr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  snap_t             snap_in,
  output logic [ADDR_W-1:0] addr_q,
  output snap_t             snap_q,
  output logic              change
);
  logic [ADDR_W-1:0] addr_d;
  snap_t             snap_d;

  always_comb begin
    change = (reg_sel != addr_q);
    addr_d = addr_q;
    snap_d = snap_q;
    if (change) begin
      addr_d = reg_sel;
      snap_d = snap_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      snap_q <= '0;
    end else begin
      addr_q <= addr_d;
      snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/nrr_delay_timer.sv
module nrr_delay_timer #(
  parameter int RESP_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CNT_W = (RESP_DELAY > 1) ? $clog2(RESP_DELAY) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESP_DELAY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    fire   = pend_q && (cnt_q == '0) && !start;
    if (start) begin
      pend_d = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = pend_q;
endmodule

// File: rtl/nrr_nibble_mux.sv
module nrr_nibble_mux
  import nrr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  snap_t             snap,
  output logic [ANS_W-1:0]  ans
);
  localparam int NUM_NIBS = 2 * NUM_FIELDS;

  logic [NIB_W-1:0] nibs [NUM_NIBS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_split
    assign nibs[2*g]   = snap.fld[g][NIB_W-1:0];
    assign nibs[2*g+1] = snap.fld[g][FIELD_W-1:NIB_W];
  end

  logic [NIB_W-1:0] data;
  logic             protect;

  always_comb begin
    data    = '0;
    protect = 1'b0;
    if (addr == REG_STATUS) begin
      data    = snap.status;
      protect = 1'b1;
    end else if (addr == REG_WEEKDAY) begin
      data    = NIB_W'(snap.wday);
      protect = 1'b1;
    end
    for (int k = 0; k < NUM_NIBS; k++) begin
      if (addr == REG_FIELD_BASE + ADDR_W'(k)) begin
        data    = nibs[k];
        protect = 1'b1;
      end
    end
  end

  always_comb begin
    if (protect)                   ans = {odd_fill(data), data};
    else if (addr == REG_LOOPBACK) ans = LOOPBACK_ANS;
    else                           ans = '0;
  end
endmodule

// File: rtl/nibble_reg_responder.sv
module nibble_reg_responder
  import nrr_pkg::*;
#(
  parameter int RESP_DELAY = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   reg_sel,
  input  logic [3:0]   status_in,
  input  logic [7:0]   sec_in,
  input  logic [7:0]   min_in,
  input  logic [7:0]   hour_in,
  input  logic [7:0]   day_in,
  input  logic [7:0]   month_in,
  input  logic [7:0]   year_in,
  input  logic [2:0]   wday_in,
  output logic [4:0]   answer
);
  snap_t             snap_in, snap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              change, busy, fire;
  logic [ANS_W-1:0]  mux_ans, ans_q, ans_d;

  always_comb begin
    snap_in.status = status_in;
    snap_in.fld[0] = sec_in;
    snap_in.fld[1] = min_in;
    snap_in.fld[2] = hour_in;
    snap_in.fld[3] = day_in;
    snap_in.fld[4] = month_in;
    snap_in.fld[5] = year_in;
    snap_in.wday   = wday_in;
  end

  nrr_snapshot u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .snap_in (snap_in),
    .addr_q  (addr_q),
    .snap_q  (snap_q),
    .change  (change)
  );

  nrr_delay_timer #(.RESP_DELAY(RESP_DELAY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (change),
    .busy  (busy),
    .fire  (fire)
  );

  nrr_nibble_mux u_mux (
    .addr (addr_q),
    .snap (snap_q),
    .ans  (mux_ans)
  );

  always_comb begin
    ans_d = ans_q;
    if (fire) ans_d = mux_ans;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ans_q <= '0;
    else        ans_q <= ans_d;
  end

  assign answer = ans_q;
endmodule

// File: rtl/nrr_checker.sv
module nrr_checker
  import nrr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_sel,
  input logic [ADDR_W-1:0] addr_q,
  input snap_t             snap_q,
  input logic              busy,
  input logic              fire,
  input logic [ANS_W-1:0]  answer
);
  AST_FEEDBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && addr_q == 5'd0) |-> (answer == 5'b00000)); // R1

  AST_LOOPBACK_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && addr_q == 5'd15) |-> (answer == 5'b01111)); // R2

  AST_UNASSIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && addr_q >= 5'd16) |-> (answer == 5'b00000)); // R3

  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && addr_q >= 5'd1 && addr_q <= 5'd14) |-> (^answer)); // R4

  AST_HOLD_UNTIL_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(answer)); // R8

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == addr_q) |=> $stable(snap_q)); // R9
endmodule

bind nibble_reg_responder nrr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_sel (reg_sel),
  .addr_q  (addr_q),
  .snap_q  (snap_q),
  .busy    (busy),
  .fire    (fire),
  .answer  (answer)
);

// File: tb/sim_nibble_reg_responder.sv
`timescale 1ns/1ps
module sim_nibble_reg_responder;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_sel = '0;
  logic [3:0] st = '0;
  logic [7:0] sec = '0, mnt = '0, hr = '0, dy = '0, mon = '0, yr = '0;
  logic [2:0] wd = '0;
  logic [4:0] answer;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] cur_ans = '0;

  int         due_q[$];
  logic [4:0] val_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nibble_reg_responder #(.RESP_DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .status_in(st),
    .sec_in(sec), .min_in(mnt), .hour_in(hr), .day_in(dy),
    .month_in(mon), .year_in(yr), .wday_in(wd), .answer(answer)
  );

  function automatic logic [4:0] model(input logic [4:0] a);
    logic [3:0] n;
    case (a)
      5'd1:  n = st;
      5'd2:  n = sec[3:0];
      5'd3:  n = sec[7:4];
      5'd4:  n = mnt[3:0];
      5'd5:  n = mnt[7:4];
      5'd6:  n = hr[3:0];
      5'd7:  n = hr[7:4];
      5'd8:  n = dy[3:0];
      5'd9:  n = dy[7:4];
      5'd10: n = mon[3:0];
      5'd11: n = mon[7:4];
      5'd12: n = yr[3:0];
      5'd13: n = yr[7:4];
      5'd14: n = {1'b0, wd};
      5'd15: return 5'b01111;
      default: return 5'b00000;
    endcase
    return {~(^n), n};
  endfunction

  task automatic push(input int due, input logic [4:0] v, input string t);
    due_q.push_back(due);
    val_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic check_now(input logic [4:0] exp, input string t);
    n_chk++;
    if (answer !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, answer, exp);
    end
  endtask

  // driver: select a register, expect old value one edge before due, new on due
  task automatic select_reg(input logic [4:0] a, input string t);
    logic [4:0] e;
    int n;
    @(negedge clk);
    e = model(a);
    reg_sel = a;
    n = cyc;
    push(n + D, cur_ans, {t, " / R8 hold before due"});
    push(n + 1 + D, e, t);
    cur_ans = e;
    repeat (D + 3) @(negedge clk);
  endtask

  // monitor: pops each expected item on its due cycle
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      int d;
      logic [4:0] v;
      string t;
      d = due_q.pop_front();
      v = val_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (d != cyc || answer !== v) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b (due %0d, seen %0d)", t, answer, v, d, cyc);
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(5'b00000, "R11 answer during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_now(5'b00000, "R11 answer after reset");

    st = 4'b1010; sec = 8'h37; mnt = 8'h5A; hr = 8'h17;
    dy = 8'h1F; mon = 8'h0C; yr = 8'h63; wd = 3'd3;

    select_reg(5'd1,  "R6 status sync+winter");
    select_reg(5'd2,  "R5 seconds low");
    select_reg(5'd3,  "R5 seconds high");
    for (int a = 4; a <= 13; a++) select_reg(5'(a), "R5 R4 field nibble");
    select_reg(5'd14, "R7 weekday");
    select_reg(5'd15, "R2 loopback pattern");
    select_reg(5'd0,  "R1 feedback zero");
    select_reg(5'd16, "R3 unassigned 16");
    select_reg(5'd23, "R3 unassigned 23");
    select_reg(5'd31, "R3 unassigned 31");

    st = 4'b0110; wd = 3'd7;
    select_reg(5'd1,  "R6 status sync+summer");
    select_reg(5'd14, "R7 weekday sunday");
    select_reg(5'd0,  "R1 feedback after data");

    // R9: inputs move one cycle after capture
    sec = 8'h59;
    begin
      logic [4:0] e;
      int n;
      @(negedge clk);
      e = model(5'd3);
      reg_sel = 5'd3;
      n = cyc;
      push(n + 1 + D, e, "R9 snapshot at change");
      cur_ans = e;
      @(negedge clk);
      sec = 8'h00;
      repeat (D + 3) @(negedge clk);
    end
    // R9: inputs move while the number is held
    sec = 8'hA4;
    repeat (D + 3) @(negedge clk);
    check_now(cur_ans, "R9 held number ignores new inputs");
    select_reg(5'd2, "R9 new number picks up fresh inputs");

    // R10: second change restarts the delay
    begin
      logic [4:0] e;
      int n, m;
      @(negedge clk);
      reg_sel = 5'd4;
      n = cyc;
      repeat (3) @(negedge clk);
      e = model(5'd5);
      reg_sel = 5'd5;
      m = cyc;
      push(n + 1 + D, cur_ans, "R10 first number not answered");
      push(m + D, cur_ans, "R10 hold before restarted due");
      push(m + 1 + D, e, "R10 newest number answered");
      cur_ans = e;
      repeat (D + 3) @(negedge clk);
    end

    wait (due_q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule